// File: doc/BRIEF.md
# Per-Port Transmit Queue with Link-Down Purge

This block holds the transmit-side queues of a multi-port Ethernet MAC. A system-side interface pushes words tagged with a port number. The queue for each port hands them to that port's MAC transmit path in first-in, first-out order. The block also reports a 2-bit fill status per port, and the system-side scheduler uses that status to decide how much more to send to each port.

Software can put any single port into a purge mode, normally while that port's link is down. In purge mode the port's queue is held cleared and the reported status is pinned at the "full enough" code, so the scheduler carries on. Anything the scheduler still sends to that port is thrown away without a trace. Clearing the bit brings the queue back empty, and normal status reporting resumes. A per-port soft reset, driven from elsewhere, also clears the queue. The purge register stays writable while that soft reset is active.

Top module: `txq_drain_ctrl`

## Requirements
- R1: `cfg_we` loads `cfg_wdata` into the purge register on the next clock edge, one bit per port; `drain_mode` shows the register and is all zero after `rst_n`.
- R2: While `drain_mode[p]` is 1, the status of port p is 2'b10 (SATISFIED), whatever the queue holds.
- R3: A port is held clear while its purge bit is set, while its `soft_rst` bit is high, or in the cycle `cfg_we` writes a 1 to its bit. After such a cycle the port is empty, and `rd_valid[p]` is 0 during any such cycle.
- R4: Words written to a port while it is held clear are dropped. This includes a write in the same cycle as the `cfg_we` that sets its bit. After exit, the port holds nothing from that period.
- R5: In the first cycle after `drain_mode[p]` falls, the status of port p is 2'b00 (STARVING).
- R6: Outside purge mode, the status follows the word count n. It is 2'b00 STARVING when n < HUNGRY_LVL, 2'b01 HUNGRY when HUNGRY_LVL <= n < SAT_LVL, and 2'b10 SATISFIED when n >= SAT_LVL.
- R7: Each port delivers its words in write order. `rd_data` slice p shows the oldest word when `rd_valid[p]` is 1. `rd_en[p]` with `rd_valid[p]` removes that word on the clock edge.
- R8: A write to a port that already holds DEPTH words is dropped. No port ever holds more than DEPTH words.
- R9: A soft reset empties the port but leaves its purge bit unchanged, and `cfg_we` still updates that bit during the soft reset.
- R10: Purge, soft reset and traffic on one port leave the status, data and validity of the other ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | NUM_PORTS | Per-port soft reset, clears that port's queue |
| cfg_we | input | 1 | Purge register write strobe |
| cfg_wdata | input | NUM_PORTS | Purge register write value, bit p for port p |
| drain_mode | output | NUM_PORTS | Current purge register value |
| wr_valid | input | 1 | System-side write strobe |
| wr_port | input | $clog2(NUM_PORTS) | Destination port of the write |
| wr_data | input | DATA_W | Write word |
| rd_en | input | NUM_PORTS | Per-port pop request from the MAC side |
| rd_valid | output | NUM_PORTS | Per-port head word available |
| rd_data | output | NUM_PORTS*DATA_W | Head word per port, port p in bits p*DATA_W upward |
| fifo_status | output | 2*NUM_PORTS | Per-port status code, port p in bits 2p+1:2p |

## Verification
The bound assertions check four things on every cycle: the pinned SATISFIED code while a port purges, that no word is valid during a clearing cycle, the STARVING code right after exit, and the loading of the purge register. They also check that a soft reset leaves no valid word behind it. Only the bench's scenarios and its queue-based model can show the rest. That covers drops at full and during purge (including the write in the same cycle as purge entry), the write-order data stream, the status thresholds as a port fills and empties, and the independence of ports.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic [1:0] {
        ST_STARVING  = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_SATISFIED = 2'b10
    } fifo_stat_e;

endpackage

// File: rtl/txq_drain_reg.sv
module txq_drain_reg #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [NUM_PORTS-1:0] cfg_wdata,
    output logic [NUM_PORTS-1:0] drain_q_o
);

    typedef struct packed {
        logic [NUM_PORTS-1:0] drain;
    } reg_s;

    reg_s reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (cfg_we) begin
            reg_d.drain = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign drain_q_o = reg_q.drain;

endmodule

// File: rtl/txq_port_fifo.sv
module txq_port_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              purge,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count_o
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } ptr_s;

    ptr_s st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic wr_ok;
    logic rd_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] ptr);
        if (ptr == AW'(DEPTH - 1)) begin
            return '0;
        end
        return ptr + AW'(1);
    endfunction

    assign rd_valid = (st_q.count != '0) && !purge;
    assign rd_data  = mem[st_q.rd_ptr];
    assign count_o  = st_q.count;

    always_comb begin
        st_d  = st_q;
        wr_ok = wr_en && !purge && (st_q.count != CW'(DEPTH));
        rd_ok = rd_en && rd_valid;
        if (purge) begin
            st_d = '0;
        end else begin
            if (wr_ok) begin
                st_d.wr_ptr = bump(st_q.wr_ptr);
            end
            if (rd_ok) begin
                st_d.rd_ptr = bump(st_q.rd_ptr);
            end
            case ({wr_ok, rd_ok})
                2'b10:   st_d.count = st_q.count + CW'(1);
                2'b01:   st_d.count = st_q.count - CW'(1);
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[st_q.wr_ptr] <= wr_data;
        end
    end

endmodule

// File: rtl/txq_status_enc.sv
module txq_status_enc
    import txq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int HUNGRY_LVL = 4,
    parameter int SAT_LVL    = 12,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic          drain,
    output fifo_stat_e    status
);

    localparam logic [CW-1:0] HUNG_C = CW'(HUNGRY_LVL);
    localparam logic [CW-1:0] SAT_C  = CW'(SAT_LVL);

    always_comb begin
        if (drain) begin
            status = ST_SATISFIED;
        end else if (count < HUNG_C) begin
            status = ST_STARVING;
        end else if (count < SAT_C) begin
            status = ST_HUNGRY;
        end else begin
            status = ST_SATISFIED;
        end
    end

endmodule

// File: rtl/txq_drain_ctrl.sv
module txq_drain_ctrl
    import txq_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 16,
    parameter int HUNGRY_LVL = 4,
    parameter int SAT_LVL    = 12,
    localparam int PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        soft_rst,
    input  logic                        cfg_we,
    input  logic [NUM_PORTS-1:0]        cfg_wdata,
    output logic [NUM_PORTS-1:0]        drain_mode,
    input  logic                        wr_valid,
    input  logic [PW-1:0]               wr_port,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [NUM_PORTS-1:0]        rd_en,
    output logic [NUM_PORTS-1:0]        rd_valid,
    output logic [NUM_PORTS*DATA_W-1:0] rd_data,
    output logic [2*NUM_PORTS-1:0]      fifo_status
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [NUM_PORTS-1:0] drain_q;
    logic [NUM_PORTS-1:0] purge;

    txq_drain_reg #(
        .NUM_PORTS (NUM_PORTS)
    ) u_drain_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .drain_q_o (drain_q)
    );

    assign drain_mode = drain_q;
    assign purge      = drain_q | soft_rst | (cfg_wdata & {NUM_PORTS{cfg_we}});

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic          wr_hit;
        logic [CW-1:0] count;
        fifo_stat_e    stat;

        assign wr_hit = wr_valid && (wr_port == PW'(p));

        txq_port_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .purge    (purge[p]),
            .wr_en    (wr_hit),
            .wr_data  (wr_data),
            .rd_en    (rd_en[p]),
            .rd_valid (rd_valid[p]),
            .rd_data  (rd_data[p*DATA_W +: DATA_W]),
            .count_o  (count)
        );

        txq_status_enc #(
            .DEPTH      (DEPTH),
            .HUNGRY_LVL (HUNGRY_LVL),
            .SAT_LVL    (SAT_LVL)
        ) u_stat (
            .count  (count),
            .drain  (drain_q[p]),
            .status (stat)
        );

        assign fifo_status[2*p +: 2] = stat;
    end

endmodule

// File: rtl/txq_drain_chk.sv
module txq_drain_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_PORTS-1:0]   soft_rst,
    input logic                   cfg_we,
    input logic [NUM_PORTS-1:0]   cfg_wdata,
    input logic [NUM_PORTS-1:0]   drain_mode,
    input logic [NUM_PORTS-1:0]   rd_valid,
    input logic [2*NUM_PORTS-1:0] fifo_status
);

    AST_DRAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (drain_mode == $past(cfg_wdata))); // R1

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_DRAIN_SATISFIED: assert property (@(posedge clk) disable iff (!rst_n)
            drain_mode[p] |-> (fifo_status[2*p +: 2] == 2'b10)); // R2

        AST_NO_VALID_PURGE: assert property (@(posedge clk) disable iff (!rst_n)
            (drain_mode[p] || soft_rst[p] || (cfg_we && cfg_wdata[p])) |-> !rd_valid[p]); // R3

        AST_EXIT_STARVING: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(drain_mode[p]) |-> (fifo_status[2*p +: 2] == 2'b00)); // R5

        AST_SRST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst[p] |=> !rd_valid[p]); // R9
    end

endmodule

bind txq_drain_ctrl txq_drain_chk #(
    .NUM_PORTS (NUM_PORTS)
) u_drain_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .drain_mode  (drain_mode),
    .rd_valid    (rd_valid),
    .fifo_status (fifo_status)
);

// File: tb/tb_txq_drain_ctrl.sv
module tb_txq_drain_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int DW  = 16;
    localparam int DEP = 8;
    localparam int HL  = 3;
    localparam int SL  = 6;
    localparam int PW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     soft_rst = '0;
    logic              cfg_we = 1'b0;
    logic [NP-1:0]     cfg_wdata = '0;
    logic [NP-1:0]     drain_mode;
    logic              wr_valid = 1'b0;
    logic [PW-1:0]     wr_port = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [NP-1:0]     rd_en = '0;
    logic [NP-1:0]     rd_valid;
    logic [NP*DW-1:0]  rd_data;
    logic [2*NP-1:0]   fifo_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int q [NP][$];
    bit m_drain [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    txq_drain_ctrl #(
        .NUM_PORTS (NP), .DATA_W (DW), .DEPTH (DEP),
        .HUNGRY_LVL (HL), .SAT_LVL (SL)
    ) dut (
        .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .drain_mode (drain_mode),
        .wr_valid (wr_valid), .wr_port (wr_port), .wr_data (wr_data),
        .rd_en (rd_en), .rd_valid (rd_valid), .rd_data (rd_data),
        .fifo_status (fifo_status)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_purge(int p);
        return m_drain[p] || soft_rst[p] || (cfg_we && cfg_wdata[p]);
    endfunction

    function automatic int m_status(int p);
        if (m_drain[p]) return 2;
        if (q[p].size() < HL) return 0;
        if (q[p].size() < SL) return 1;
        return 2;
    endfunction

    // compare all outputs against the model for the current inputs
    task automatic compare_all();
        for (int p = 0; p < NP; p++) begin
            bit ev;
            ev = (q[p].size() > 0) && !m_purge(p);
            check("R1", "drain bit", int'(drain_mode[p]), int'(m_drain[p]));
            check(m_drain[p] ? "R2" : "R6", "status", int'(fifo_status[2*p +: 2]), m_status(p));
            check(m_purge(p) ? "R3" : "R7", "rd_valid", int'(rd_valid[p]), int'(ev));
            if (ev) check("R7", "rd_data", int'(rd_data[p*DW +: DW]), q[p][0]);
        end
    endtask

    task automatic step();
        bit pop [NP];
        bit push [NP];
        #1;
        compare_all();
        for (int p = 0; p < NP; p++) begin
            pop[p]  = rd_en[p] && (q[p].size() > 0) && !m_purge(p);
            push[p] = wr_valid && (int'(wr_port) == p) && !m_purge(p) && (q[p].size() < DEP);
        end
        @(posedge clk);
        for (int p = 0; p < NP; p++) begin
            if (m_purge(p)) begin
                q[p].delete();
            end else begin
                if (pop[p]) void'(q[p].pop_front());
                if (push[p]) q[p].push_back(int'(wr_data));
            end
        end
        if (cfg_we) for (int p = 0; p < NP; p++) m_drain[p] = cfg_wdata[p];
        @(negedge clk);
    endtask

    task automatic idle();
        wr_valid = 0; rd_en = '0; cfg_we = 0;
    endtask

    task automatic write(int p, int d);
        wr_valid = 1; wr_port = PW'(p); wr_data = DW'(d);
        step();
        wr_valid = 0;
    endtask

    task automatic read(int p);
        rd_en[p] = 1;
        step();
        rd_en[p] = 0;
    endtask

    task automatic set_drain(logic [NP-1:0] v);
        cfg_we = 1; cfg_wdata = v;
        step();
        cfg_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) m_drain[p] = 0;
        repeat (3) @(negedge clk);
        // reset state, R1
        check("R1", "drain after reset", int'(drain_mode), 0);
        check("R6", "status after reset", int'(fifo_status), 0);
        rst_n = 1;
        @(negedge clk);
        step();

        // fill port 0 through the status thresholds, R6 / R7
        for (int i = 0; i < 7; i++) write(0, 16'h100 + i);
        check("R6", "port0 status at 7", int'(fifo_status[1:0]), 2);
        for (int i = 0; i < 3; i++) read(0);
        check("R6", "port0 status at 4", int'(fifo_status[1:0]), 1);
        check("R7", "port0 head", int'(rd_data[DW-1:0]), 16'h103);

        // overflow on port 1, R8
        for (int i = 0; i < DEP + 3; i++) write(1, 16'h200 + i);
        for (int i = 0; i < DEP; i++) begin
            check("R8", "port1 order", int'(rd_data[DW +: DW]), 16'h200 + i);
            read(1);
        end
        check("R8", "port1 empty after DEPTH reads", int'(rd_valid[1]), 0);

        // purge port 2 with data; write in the entry cycle, R3 / R4 / R10
        for (int i = 0; i < 4; i++) write(2, 16'h300 + i);
        cfg_we = 1; cfg_wdata = 4'b0100;
        wr_valid = 1; wr_port = 2; wr_data = 16'h3ff;
        step();
        idle();
        check("R2", "port2 pinned", int'(fifo_status[5:4]), 2);
        check("R10", "port0 status kept", int'(fifo_status[1:0]), 1);
        check("R10", "port0 valid kept", int'(rd_valid[0]), 1);
        for (int i = 0; i < 5; i++) write(2, 16'h310 + i);
        set_drain(4'b0000);
        check("R5", "port2 status after exit", int'(fifo_status[5:4]), 0);
        check("R4", "port2 nothing kept", int'(rd_valid[2]), 0);
        write(2, 16'h320);
        check("R4", "port2 fresh head", int'(rd_data[2*DW +: DW]), 16'h320);

        // soft reset on port 3 with purge bit written meanwhile, R9
        for (int i = 0; i < 6; i++) write(3, 16'h400 + i);
        soft_rst[3] = 1;
        step();
        set_drain(4'b1000);
        soft_rst[3] = 0;
        step();
        check("R9", "port3 bit set during soft reset", int'(drain_mode[3]), 1);
        set_drain(4'b0000);
        check("R9", "port3 empty after soft reset", int'(rd_valid[3]), 0);
        check("R10", "port0 unaffected", int'(rd_data[DW-1:0]), 16'h103);

        // mixed traffic with random purge toggles
        for (int c = 0; c < 3000; c++) begin
            wr_valid = ($urandom_range(0, 3) != 0);
            wr_port  = PW'($urandom_range(0, NP - 1));
            wr_data  = DW'($urandom);
            rd_en    = NP'($urandom);
            cfg_we   = ($urandom_range(0, 40) == 0);
            cfg_wdata = NP'($urandom) & NP'($urandom);
            soft_rst = ($urandom_range(0, 60) == 0) ? NP'($urandom) : '0;
            step();
        end
        idle();
        soft_rst = '0;
        step();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule